// File: doc/BRIEF.md
# Filtered Multicore Snoop Dispatcher

This block sits in front of the snoop queue of a shared last-level cache in a four-core chip. Each incoming request (a data read miss, a read for ownership, a code fetch or an eviction from the shared cache) names the core that raised it. It also carries two semantic tags, one marking a stack access and one asking not to be snooped, plus a hit flag from an external filter that tracks non-stack addresses. From these the block computes a per-core probe target mask. It does not broadcast every request to every other core. The aim is that other cores spend no cache energy on probes that cannot find anything.

A request with a non-zero mask is written into a small first-in first-out probe queue, which the snoop controller drains through a valid/ready pair. A request whose mask comes out all zero is acknowledged at once and never enters the queue. When the queue is full, requests that would need a slot are held off through the request handshake.

Top module: `snoop_dispatch`

## Requirements
- R1: An eviction request (kind code 3) yields mask 1111, including the requester's own bit, whatever its stack, no-snoop and filter inputs are.
- R2: A non-eviction request (kind 0 read, 1 ownership read, 2 code fetch) with the no-snoop tag set yields an all-zero mask.
- R3: A non-eviction request with the stack tag set yields an all-zero mask.
- R4: A non-eviction request with both tags clear and the filter hit low yields an all-zero mask.
- R5: A non-eviction request with both tags clear and the filter hit high targets every core except the requester, where mask bit i stands for core i.
- R6: A request with an all-zero mask sees req_ready high even when the queue is full, and nothing is enqueued for it.
- R7: Accepted probes leave in acceptance order with their address. A probe accepted at a clock edge is visible on probe_valid and probe_mask right after that edge.
- R8: The queue holds DEPTH probes (default 4). While it is full, a request with a non-zero mask sees req_ready low and is not taken.
- R9: After reset, probe_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle |
| req_kind | input | 2 | 0 read miss, 1 ownership read, 2 code fetch, 3 eviction |
| req_core | input | 2 | Requesting core index |
| req_stack | input | 1 | Stack-access tag |
| req_no_snoop | input | 1 | Do-not-snoop tag |
| req_filter_hit | input | 1 | Non-stack filter reports a possible hit |
| req_addr | input | ADDR_W | Line address |
| probe_valid | output | 1 | Queue head holds a probe |
| probe_ready | input | 1 | Snoop controller takes the head |
| probe_mask | output | NUM_CORES | Cores to probe |
| probe_addr | output | ADDR_W | Address of the probe |

## Verification
The hardest state to reach from the ports is a full queue meeting a request that needs no probe. Only there do the zero-mask bypass and the back-pressure rule pull in opposite directions. The bench holds probe_ready low, fills the queue with evictions, and then offers first a fifth eviction and then a stack-tagged read. On draining, it confirms that exactly the four queued probes come out in order. Random traffic with long spells of low probe_ready keeps returning to the full condition, and a bench-side queue model checks each handshake.

// File: rtl/snoop_dispatch_pkg.sv
// Shared request kind codes for the snoop dispatcher.
// Assumes a 2-bit kind field on the request port.
package snoop_dispatch_pkg;
    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_OWN   = 2'd1,
        KIND_CODE  = 2'd2,
        KIND_EVICT = 2'd3
    } req_kind_e;
endpackage

// File: rtl/snoop_target_sel.sv
// Combinational probe target selection.
// Applies, in priority order, eviction (all cores), no-snoop tag,
// stack tag, then filter hit; the requester is excluded unless evicting.
// Assumes req_core < NUM_CORES.
module snoop_target_sel
    import snoop_dispatch_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = 2
) (
    input  logic [1:0]           kind,
    input  logic [CORE_W-1:0]    core,
    input  logic                 stack,
    input  logic                 no_snoop,
    input  logic                 filter_hit,
    output logic [NUM_CORES-1:0] mask
);
    logic is_evict;
    logic allow;

    // Decide whether any probe is needed at all.
    always_comb begin
        is_evict = (kind == KIND_EVICT);
        if (is_evict)      allow = 1'b1;
        else if (no_snoop) allow = 1'b0;
        else if (stack)    allow = 1'b0;
        else               allow = filter_hit;
    end

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_bit
        // Per-core target bit, self-excluded unless evicting.
        always_comb mask[i] = allow & (is_evict | (core != CORE_W'(i)));
    end
endmodule

// File: rtl/snoop_probe_fifo.sv
// First-in first-out probe queue with full/empty flags.
// Assumes the writer never writes when full and the reader never
// reads when empty; DEPTH need not be a power of two.
module snoop_probe_fifo #(
    parameter int WIDTH = 20,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            if (wr_en && !rd_en)      count <= count + 1'b1;
            else if (!wr_en && rd_en) count <= count - 1'b1;
        end
    end

    // Store written entries.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    // Present head entry and flags.
    always_comb begin
        rd_data = mem[rd_ptr];
        full    = (count == CNT_W'(DEPTH));
        empty   = (count == '0);
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr_en);
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !rd_en);
    p_write_shows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !empty);
endmodule

// File: rtl/snoop_dispatch.sv
// Top of the filtered snoop dispatcher: computes a per-core probe mask
// for each request, enqueues non-empty masks and acknowledges empty ones
// immediately. Assumes a single request per cycle.
module snoop_dispatch
    import snoop_dispatch_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 16,
    parameter int DEPTH     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [1:0]                    req_kind,
    input  logic [$clog2(NUM_CORES)-1:0]  req_core,
    input  logic                          req_stack,
    input  logic                          req_no_snoop,
    input  logic                          req_filter_hit,
    input  logic [ADDR_W-1:0]             req_addr,
    output logic                          probe_valid,
    input  logic                          probe_ready,
    output logic [NUM_CORES-1:0]          probe_mask,
    output logic [ADDR_W-1:0]             probe_addr
);
    localparam int CORE_W  = $clog2(NUM_CORES);
    localparam int ENTRY_W = NUM_CORES + ADDR_W;

    logic [NUM_CORES-1:0] sel_mask;
    logic                 q_full, q_empty, push, pop, needs_probe;
    logic [ENTRY_W-1:0]   head;

    snoop_target_sel #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_sel (
        .kind(req_kind), .core(req_core), .stack(req_stack),
        .no_snoop(req_no_snoop), .filter_hit(req_filter_hit), .mask(sel_mask)
    );

    // Handshake: empty masks bypass, others need a free slot.
    always_comb begin
        needs_probe = |sel_mask;
        req_ready   = !needs_probe || !q_full;
        push        = req_valid && needs_probe && !q_full;
        pop         = probe_valid && probe_ready;
    end

    snoop_probe_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_data({sel_mask, req_addr}),
        .rd_en(pop), .rd_data(head), .full(q_full), .empty(q_empty)
    );

    // Split the queue head into the probe fields.
    always_comb begin
        probe_valid = !q_empty;
        probe_mask  = head[ENTRY_W-1:ADDR_W];
        probe_addr  = head[ADDR_W-1:0];
    end

    p_evict_all_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == KIND_EVICT) |-> (sel_mask == '1));
    p_no_snoop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind != KIND_EVICT && req_no_snoop) |-> (sel_mask == '0));
    p_stack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind != KIND_EVICT && req_stack) |-> (sel_mask == '0));
    p_self_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind != KIND_EVICT) |-> !sel_mask[req_core]);
    p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_mask == '0) |-> req_ready);
    p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && !pop) |=> q_full);
    p_probe_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid |-> (probe_mask != '0));
endmodule

// File: tb/test_snoop_dispatch.sv
module test_snoop_dispatch;
    localparam int NC = 4;
    localparam int AW = 16;
    localparam int DEPTH = 4;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_ready;
    logic [1:0] req_kind = 0, req_core = 0;
    logic req_stack = 0, req_no_snoop = 0, req_filter_hit = 0;
    logic [AW-1:0] req_addr = 0;
    logic probe_valid, probe_ready = 0;
    logic [NC-1:0] probe_mask;
    logic [AW-1:0] probe_addr;

    int checks = 0, failures = 0;
    logic [NC+AW-1:0] mq [$];
    bit done = 0;

    always #2 clk = ~clk;

    snoop_dispatch #(.NUM_CORES(NC), .ADDR_W(AW), .DEPTH(DEPTH)) i_snoop_dispatch (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_core(req_core), .req_stack(req_stack),
        .req_no_snoop(req_no_snoop), .req_filter_hit(req_filter_hit),
        .req_addr(req_addr), .probe_valid(probe_valid), .probe_ready(probe_ready),
        .probe_mask(probe_mask), .probe_addr(probe_addr)
    );

    function automatic logic [NC-1:0] exp_mask(input logic [1:0] k, input logic [1:0] c,
                                               input logic s, input logic n, input logic h);
        if (k == 2'd3) return '1;
        if (n || s || !h) return '0;
        return ~(NC'(1) << c);
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] k, input logic [1:0] c, input logic s,
                         input logic n, input logic h, input logic [AW-1:0] a);
        req_valid = 1; req_kind = k; req_core = c; req_stack = s;
        req_no_snoop = n; req_filter_hit = h; req_addr = a;
    endtask

    // One request on an empty queue; check what lands at the head.
    task automatic send_one(input logic [1:0] k, input logic [1:0] c, input logic s,
                            input logic n, input logic h, input logic [AW-1:0] a,
                            input string tag);
        logic [NC-1:0] e;
        e = exp_mask(k, c, s, n, h);
        @(negedge clk); probe_ready = 0; drive(k, c, s, n, h, a);
        #1 check(req_ready == 1, tag, req_ready, 1);
        @(negedge clk); req_valid = 0;
        #1;
        if (e != 0) begin
            check(probe_valid && probe_mask == e && probe_addr == a, tag,
                  {probe_valid, probe_mask, probe_addr}, {1'b1, e, a});
            probe_ready = 1;
            @(negedge clk); probe_ready = 0;
        end else begin
            check(probe_valid == 0, tag, probe_valid, 0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A1E));
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        check(probe_valid == 0, "R9 probe_valid", probe_valid, 0);
        check(req_ready == 1, "R9 req_ready", req_ready, 1);

        // Directed rules
        send_one(2'd3, 2'd1, 1, 1, 0, 16'h1001, "R1 evict tagged");
        send_one(2'd3, 2'd0, 0, 0, 1, 16'h1002, "R1 evict plain");
        send_one(2'd0, 2'd2, 0, 1, 1, 16'h1003, "R2 no-snoop read");
        send_one(2'd1, 2'd0, 0, 1, 1, 16'h1004, "R2 no-snoop own");
        send_one(2'd0, 2'd1, 1, 0, 1, 16'h1005, "R3 stack read");
        send_one(2'd2, 2'd3, 1, 0, 1, 16'h1006, "R3 stack code");
        send_one(2'd0, 2'd0, 0, 0, 0, 16'h1007, "R4 filter miss");
        send_one(2'd0, 2'd0, 0, 0, 1, 16'h1008, "R5 read core0");
        send_one(2'd1, 2'd2, 0, 0, 1, 16'h1009, "R5 own core2");
        send_one(2'd2, 2'd3, 0, 0, 1, 16'h100A, "R5 code core3");

        // Fill the queue, then probe the full condition
        probe_ready = 0;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk); drive(2'd3, 2'(i), 0, 0, 0, AW'(16'h2000 + i));
        end
        @(negedge clk); drive(2'd3, 2'd0, 0, 0, 0, 16'h2FFF);
        #1 check(req_ready == 0, "R8 full holds evict", req_ready, 0);
        drive(2'd0, 2'd1, 1, 0, 1, 16'h2EEE);
        #1 check(req_ready == 1, "R6 bypass when full", req_ready, 1);
        @(negedge clk); req_valid = 0; probe_ready = 1;
        for (int i = 0; i < DEPTH; i++) begin
            #1 check(probe_valid && probe_addr == AW'(16'h2000 + i) && probe_mask == 4'hF,
                     "R7 order", {probe_valid, probe_addr}, {1'b1, AW'(16'h2000 + i)});
            @(negedge clk);
        end
        #1 check(probe_valid == 0, "R8 nothing extra queued", probe_valid, 0);
        probe_ready = 0;

        // Random traffic against a queue model
        for (int cyc = 0; cyc < 4000; cyc++) begin
            logic [NC-1:0] e;
            bit rdy_exp;
            @(negedge clk);
            drive(2'($urandom), 2'($urandom), ($urandom % 4) == 0, ($urandom % 5) == 0,
                  ($urandom % 3) != 0, AW'($urandom));
            req_valid = ($urandom % 4) != 0;
            probe_ready = ((cyc / 64) % 2 == 0) ? (($urandom % 2) == 0) : (($urandom % 6) == 0);
            #1;
            e = exp_mask(req_kind, req_core, req_stack, req_no_snoop, req_filter_hit);
            rdy_exp = (e == 0) || (mq.size() < DEPTH);
            check(req_ready == rdy_exp, (e == 0) ? "R6 ready" : "R8 ready", req_ready, rdy_exp);
            check(probe_valid == (mq.size() != 0), "R7 valid", probe_valid, mq.size() != 0);
            if (mq.size() != 0)
                check({probe_mask, probe_addr} == mq[0], "R7 head",
                      {probe_mask, probe_addr}, mq[0]);
            if (probe_valid && probe_ready && mq.size() != 0) void'(mq.pop_front());
            if (req_valid && rdy_exp && e != 0) mq.push_back({e, req_addr});
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule